// File: doc/BRIEF.md
# Circular Queue Pointer Manager

This block keeps the producer and consumer pointers of a circular queue whose entries live in memory, for example a command queue or an event queue. Software programs a base register, the two pointer registers and an enable bit over a single-cycle register-write port. Hardware on the queue's two sides then reports one produced entry or one finished consumption per cycle. The block works out full and empty, and the byte addresses of the next entry to read and the next slot to write.

The queue holds 2^L entries. L comes from the low five bits of the base register. Software may write a value above the supported maximum. The field then reads back as written, but the queue behaves as if the maximum had been written. Each pointer holds an index in bits [L-1:0] and a wrap flag at bit L. Because L is set at run time, the wrap flag moves with it. A command error is recorded in a field of the consumer register, and the pointer is left where it was. This lets the consumer stall on the failing entry.

Top module: `cq_ptr_mgr`

## Requirements
- R1: In reset and right after it, every read-back register is zero, the queue is disabled, `q_empty` is 1, and `q_full` and `q_overflow` are 0.
- R2: A write to the base register (select 0) reads back all 32 bits unchanged. From the next cycle the effective size L is the smaller of data bits [4:0] and `MAX_LOG2`.
- R3: When the queue is enabled and not full, `produce_req` adds one to the producer pointer modulo 2^(L+1). The index therefore rolls from 2^L-1 to 0 and the wrap bit at position L toggles.
- R4: A `produce_req` against a full, enabled queue leaves the producer unchanged and sets a sticky overflow flag. The flag is seen on `q_overflow` and on `prod_rdata` bit 31, and a software write to the producer register (select 1) clears it.
- R5: When the queue is enabled and not empty, `consume_done` advances the consumer pointer in the same way as R3. A `consume_done` against an empty queue has no effect.
- R6: `q_full` is 1 exactly when the two indices are equal and the wrap bits differ. `q_empty` is 1 exactly when index and wrap bit are both equal. Both compare only the low L+1 pointer bits.
- R7: `rd_entry_addr` equals (base & ~0x1F) + `ENTRY_BYTES` × consumer index, and `wr_entry_addr` equals the same sum with the producer index.
- R8: When the queue is enabled, `err_req` writes `err_code` into bits [30:24] of the consumer register. It leaves the consumer pointer unchanged and suppresses a `consume_done` in the same cycle. A consumer-register write (select 2) loads those bits from data [30:24].
- R9: Bit 0 of the control register (select 3) enables the queue. While the queue is disabled, `produce_req`, `consume_done` and `err_req` change nothing.
- R10: In a cycle with `reg_wr_en` high, all three hardware requests are ignored and only the register write takes effect.
- R11: A software write to either pointer keeps only the low L+1 bits of the data, using the L in force at the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | 0 base, 1 producer, 2 consumer, 3 control |
| reg_wr_data | input | 32 | Write data |
| produce_req | input | 1 | One entry written by the producer side |
| consume_done | input | 1 | Current entry fully processed |
| err_req | input | 1 | Record an error on the current entry |
| err_code | input | 7 | Error type to record |
| base_rdata | output | 32 | Base register as written |
| prod_rdata | output | 32 | Overflow flag (bit 31) and producer pointer |
| cons_rdata | output | 32 | Error field [30:24] and consumer pointer |
| q_enabled | output | 1 | Queue enable bit |
| q_full | output | 1 | Queue full |
| q_empty | output | 1 | Queue empty |
| q_overflow | output | 1 | Sticky overflow flag |
| rd_entry_addr | output | 32 | Address of the entry at the consumer |
| wr_entry_addr | output | 32 | Address of the slot at the producer |

## Verification
Every register update, whether from software or from hardware, shows on the read-back outputs one clock edge after the cycle that requests it. Full, empty and both addresses are decoded from registers only, so they move in that same cycle and never follow the inputs directly. The bench drives inputs on the falling edge and advances its behavioural model on the rising edge. It compares every output on the following falling edge, when both the model and the design sit one update past the request. The directed checks are placed on that same falling edge.

// File: rtl/cqpm_pkg.sv
package cqpm_pkg;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_PROD = 2'd1,
    SEL_CONS = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  localparam int SIZE_W  = 5;
  localparam int ERR_W   = 7;
  localparam int ERR_LSB = 24;

  // single bit at the wrap position
  function automatic logic [31:0] fn_wrap_bit(input logic [SIZE_W-1:0] l);
    return 32'd1 << l;
  endfunction

  function automatic logic [31:0] fn_index_mask(input logic [SIZE_W-1:0] l);
    return fn_wrap_bit(l) - 32'd1;
  endfunction

  // index plus wrap bit
  function automatic logic [31:0] fn_span_mask(input logic [SIZE_W-1:0] l);
    return (fn_wrap_bit(l) << 1) - 32'd1;
  endfunction

  function automatic logic fn_is_full(input logic [31:0] p, input logic [31:0] c,
                                      input logic [SIZE_W-1:0] l);
    return ((p ^ c) & fn_span_mask(l)) == fn_wrap_bit(l);
  endfunction

  function automatic logic fn_is_empty(input logic [31:0] p, input logic [31:0] c,
                                       input logic [SIZE_W-1:0] l);
    return (p & fn_span_mask(l)) == (c & fn_span_mask(l));
  endfunction

  function automatic logic [31:0] fn_advance(input logic [31:0] p,
                                             input logic [SIZE_W-1:0] l);
    return (p + 32'd1) & fn_span_mask(l);
  endfunction

  function automatic logic [SIZE_W-1:0] fn_clamp(input logic [SIZE_W-1:0] f,
                                                 input logic [SIZE_W-1:0] mx);
    return (f > mx) ? mx : f;
  endfunction

  function automatic logic [31:0] fn_entry_addr(input logic [31:0] base_addr,
                                                input logic [31:0] ptr,
                                                input logic [SIZE_W-1:0] l,
                                                input logic [31:0] ebytes);
    return base_addr + ebytes * (ptr & fn_index_mask(l));
  endfunction

endpackage

// File: rtl/cqpm_size_reg.sv
module cqpm_size_reg
  import cqpm_pkg::*;
#(
  parameter int MAX_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [31:0]       data,
  output logic [31:0]       base_raw,
  output logic [31:0]       base_addr,
  output logic [SIZE_W-1:0] eff_log2
);
  localparam logic [SIZE_W-1:0] MAX_L = SIZE_W'(MAX_LOG2);

  logic [31:0]       base_q;
  logic [SIZE_W-1:0] eff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      eff_q  <= '0;
    end else if (wr) begin
      base_q <= data;
      eff_q  <= fn_clamp(data[SIZE_W-1:0], MAX_L);
    end
  end

  assign base_raw  = base_q;
  assign base_addr = base_q & ~32'h1F;
  assign eff_log2  = eff_q;

  // in-range size takes effect as written
  assert_size_inrange_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && data[SIZE_W-1:0] <= MAX_L) |=> (eff_log2 == $past(data[SIZE_W-1:0])));

  // over-range size is pinned to the maximum
  assert_size_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && data[SIZE_W-1:0] > MAX_L) |=> (eff_log2 == MAX_L));

endmodule

// File: rtl/cqpm_ptr.sv
module cqpm_ptr
  import cqpm_pkg::*;
#(
  parameter int PW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [31:0]       sw_val,
  input  logic              adv,
  input  logic [SIZE_W-1:0] l,
  output logic [PW-1:0]     ptr
);
  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_nxt;

  always_comb begin
    if (sw_wr)    ptr_nxt = PW'(sw_val & fn_span_mask(l));
    else if (adv) ptr_nxt = PW'(fn_advance(32'(ptr_q), l));
    else          ptr_nxt = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_nxt;
  end

  assign ptr = ptr_q;

  // without a request the pointer holds
  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && !adv) |=> $stable(ptr));

  // an advance always moves the pointer
  assert_ptr_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && adv) |=> !$stable(ptr));

endmodule

// File: rtl/cqpm_status.sv
module cqpm_status
  import cqpm_pkg::*;
#(
  parameter int ENTRY_BYTES = 16
) (
  input  logic [31:0]       prod,
  input  logic [31:0]       cons,
  input  logic [SIZE_W-1:0] l,
  input  logic [31:0]       base_addr,
  output logic              full,
  output logic              empty,
  output logic [31:0]       rd_addr,
  output logic [31:0]       wr_addr
);
  localparam logic [31:0] EB = 32'(ENTRY_BYTES);

  always_comb begin
    full    = fn_is_full(prod, cons, l);
    empty   = fn_is_empty(prod, cons, l);
    rd_addr = fn_entry_addr(base_addr, cons, l, EB);
    wr_addr = fn_entry_addr(base_addr, prod, l, EB);
  end

endmodule

// File: rtl/cq_ptr_mgr.sv
module cq_ptr_mgr
  import cqpm_pkg::*;
#(
  parameter int MAX_LOG2    = 8,
  parameter int ENTRY_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [1:0]  reg_wr_sel,
  input  logic [31:0] reg_wr_data,
  input  logic        produce_req,
  input  logic        consume_done,
  input  logic        err_req,
  input  logic [6:0]  err_code,
  output logic [31:0] base_rdata,
  output logic [31:0] prod_rdata,
  output logic [31:0] cons_rdata,
  output logic        q_enabled,
  output logic        q_full,
  output logic        q_empty,
  output logic        q_overflow,
  output logic [31:0] rd_entry_addr,
  output logic [31:0] wr_entry_addr
);
  localparam int PW = MAX_LOG2 + 1;

  logic [31:0]       base_addr;
  logic [SIZE_W-1:0] eff_log2;
  logic [PW-1:0]     prod_ptr;
  logic [PW-1:0]     cons_ptr;
  logic              en_q;
  logic              ovf_q;
  logic [ERR_W-1:0]  err_q;

  // named events
  logic wr_base, wr_prod, wr_cons, wr_ctrl;
  logic hw_ok, do_produce, produce_refused, do_consume, do_err;

  assign wr_base = reg_wr_en && (reg_wr_sel == SEL_BASE);
  assign wr_prod = reg_wr_en && (reg_wr_sel == SEL_PROD);
  assign wr_cons = reg_wr_en && (reg_wr_sel == SEL_CONS);
  assign wr_ctrl = reg_wr_en && (reg_wr_sel == SEL_CTRL);

  assign hw_ok           = en_q && !reg_wr_en;
  assign do_produce      = hw_ok && produce_req && !q_full;
  assign produce_refused = hw_ok && produce_req && q_full;
  assign do_err          = hw_ok && err_req;
  assign do_consume      = hw_ok && consume_done && !err_req && !q_empty;

  cqpm_size_reg #(.MAX_LOG2(MAX_LOG2)) u_size (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr_base),
    .data     (reg_wr_data),
    .base_raw (base_rdata),
    .base_addr(base_addr),
    .eff_log2 (eff_log2)
  );

  cqpm_ptr #(.PW(PW)) u_prod (
    .clk   (clk),
    .rst_n (rst_n),
    .sw_wr (wr_prod),
    .sw_val(reg_wr_data),
    .adv   (do_produce),
    .l     (eff_log2),
    .ptr   (prod_ptr)
  );

  cqpm_ptr #(.PW(PW)) u_cons (
    .clk   (clk),
    .rst_n (rst_n),
    .sw_wr (wr_cons),
    .sw_val(reg_wr_data),
    .adv   (do_consume),
    .l     (eff_log2),
    .ptr   (cons_ptr)
  );

  cqpm_status #(.ENTRY_BYTES(ENTRY_BYTES)) u_stat (
    .prod     (32'(prod_ptr)),
    .cons     (32'(cons_ptr)),
    .l        (eff_log2),
    .base_addr(base_addr),
    .full     (q_full),
    .empty    (q_empty),
    .rd_addr  (rd_entry_addr),
    .wr_addr  (wr_entry_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ovf_q <= 1'b0;
      err_q <= '0;
    end else begin
      if (wr_ctrl) en_q <= reg_wr_data[0];
      if (wr_prod) ovf_q <= 1'b0;
      else if (produce_refused) ovf_q <= 1'b1;
      if (wr_cons) err_q <= reg_wr_data[ERR_LSB +: ERR_W];
      else if (do_err) err_q <= err_code;
    end
  end

  assign q_enabled  = en_q;
  assign q_overflow = ovf_q;
  assign prod_rdata = {ovf_q, {(31-PW){1'b0}}, prod_ptr};
  assign cons_rdata = {1'b0, err_q, {(ERR_LSB-PW){1'b0}}, cons_ptr};

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    produce_refused |=> (q_overflow && $stable(prod_ptr)));

  assert_empty_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_ok && consume_done && q_empty) |=> $stable(cons_ptr));

  assert_full_empty_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty));

  assert_err_keeps_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    do_err |=> ($stable(cons_ptr) && cons_rdata[30:24] == $past(err_code)));

  assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !reg_wr_en) |=> ($stable(prod_ptr) && $stable(cons_ptr) && $stable(err_q)));

  assert_ctrl_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ($stable(prod_ptr) && $stable(cons_ptr) && $stable(ovf_q)));

endmodule

// File: tb/cq_ptr_mgr_tb.sv
`timescale 1ns/1ps
module cq_ptr_mgr_tb_top;
  localparam int MAXL = 8;
  localparam int EB   = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_sel = 2'd0;
  logic [31:0] reg_wr_data = '0;
  logic        produce_req = 1'b0;
  logic        consume_done = 1'b0;
  logic        err_req = 1'b0;
  logic [6:0]  err_code = '0;
  logic [31:0] base_rdata, prod_rdata, cons_rdata, rd_entry_addr, wr_entry_addr;
  logic        q_enabled, q_full, q_empty, q_overflow;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cq_ptr_mgr #(.MAX_LOG2(MAXL), .ENTRY_BYTES(EB)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .produce_req(produce_req), .consume_done(consume_done),
    .err_req(err_req), .err_code(err_code), .base_rdata(base_rdata),
    .prod_rdata(prod_rdata), .cons_rdata(cons_rdata), .q_enabled(q_enabled),
    .q_full(q_full), .q_empty(q_empty), .q_overflow(q_overflow),
    .rd_entry_addr(rd_entry_addr), .wr_entry_addr(wr_entry_addr)
  );

  // behavioural reference state
  logic [31:0] m_base = '0;
  int m_l = 0, m_prod = 0, m_cons = 0, m_err = 0, m_en = 0, m_ovf = 0;

  function automatic int m_idx(int p);  return p % (1 << m_l);      endfunction
  function automatic int m_wrap(int p); return (p >> m_l) & 1;      endfunction
  function automatic int m_mod();       return 2 * (1 << m_l);      endfunction
  function automatic int m_full();
    return (m_idx(m_prod) == m_idx(m_cons) && m_wrap(m_prod) != m_wrap(m_cons)) ? 1 : 0;
  endfunction
  function automatic int m_empty();
    return (m_idx(m_prod) == m_idx(m_cons) && m_wrap(m_prod) == m_wrap(m_cons)) ? 1 : 0;
  endfunction
  function automatic logic [31:0] m_addr(int p);
    return {m_base[31:5], 5'd0} + 32'(EB * m_idx(p));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base = '0; m_l = 0; m_prod = 0; m_cons = 0; m_err = 0; m_en = 0; m_ovf = 0;
    end else if (reg_wr_en) begin
      case (reg_wr_sel)
        2'd0: begin m_base = reg_wr_data; m_l = (int'(reg_wr_data[4:0]) > MAXL) ? MAXL : int'(reg_wr_data[4:0]); end
        2'd1: begin m_prod = int'(reg_wr_data[15:0]) % m_mod(); m_ovf = 0; end
        2'd2: begin m_cons = int'(reg_wr_data[15:0]) % m_mod(); m_err = int'(reg_wr_data[30:24]); end
        default: m_en = int'(reg_wr_data[0]);
      endcase
    end else if (m_en != 0) begin
      int f, e;
      f = m_full(); e = m_empty();
      if (err_req) m_err = int'(err_code);
      if (produce_req) begin
        if (f != 0) m_ovf = 1;
        else m_prod = (m_prod + 1) % m_mod();
      end
      if (consume_done && !err_req && e == 0) m_cons = (m_cons + 1) % m_mod();
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 base_rdata", base_rdata, m_base);
      chk("R3 R4 prod_rdata", prod_rdata, 32'(m_prod) | (32'(m_ovf) << 31));
      chk("R5 R8 cons_rdata", cons_rdata, 32'(m_cons) | (32'(m_err) << 24));
      chk("R9 q_enabled", 32'(q_enabled), 32'(m_en));
      chk("R6 q_full", 32'(q_full), 32'(m_full()));
      chk("R6 q_empty", 32'(q_empty), 32'(m_empty()));
      chk("R4 q_overflow", 32'(q_overflow), 32'(m_ovf));
      chk("R7 rd_entry_addr", rd_entry_addr, m_addr(m_cons));
      chk("R7 wr_entry_addr", wr_entry_addr, m_addr(m_prod));
    end
  end

  task automatic step(bit w, logic [1:0] s, logic [31:0] d, bit p, bit c, bit e, logic [6:0] code);
    reg_wr_en = w; reg_wr_sel = s; reg_wr_data = d;
    produce_req = p; consume_done = c; err_req = e; err_code = code;
    @(negedge clk);
    reg_wr_en = 0; produce_req = 0; consume_done = 0; err_req = 0;
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d); step(1, s, d, 0, 0, 0, 7'd0); endtask
  task automatic hw(bit p, bit c); step(0, 2'd0, 0, p, c, 0, 7'd0); endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset prod", prod_rdata, 0);
    chk("R1 reset cons", cons_rdata, 0);
    chk("R1 reset empty", 32'(q_empty), 1);
    chk("R1 reset full", 32'(q_full), 0);
    chk("R1 reset en", 32'(q_enabled), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release ovf", 32'(q_overflow), 0);

    wr(2'd3, 32'd1);
    wr(2'd0, 32'h1000_0003);               // 8 entries
    for (int i = 0; i < 9; i++) hw(1, 0);  // ninth refused
    chk("R4 overflow after 9 produces", 32'(q_overflow), 1);
    chk("R6 full after 8", 32'(q_full), 1);
    for (int i = 0; i < 9; i++) hw(0, 1);  // ninth on empty
    chk("R5 empty after drain", 32'(q_empty), 1);
    for (int i = 0; i < 20; i++) hw(1, (i % 3) != 0);

    // R8 error with a simultaneous consume
    hw(1, 0); hw(1, 0);
    step(0, 2'd0, 0, 0, 1, 1, 7'h55);
    chk("R8 err field", 32'(cons_rdata[30:24]), 32'h55);
    wr(2'd2, 32'(m_cons));
    chk("R8 err cleared", 32'(cons_rdata[30:24]), 0);

    // R9 disabled
    wr(2'd3, 32'd0);
    step(0, 2'd0, 0, 1, 1, 1, 7'h11);
    hw(1, 0);
    wr(2'd3, 32'd1);

    // R11 pointer write masking; R4 clear
    wr(2'd1, 32'h0000_01FF);
    chk("R11 prod masked", prod_rdata, 32'h0000_000F);
    chk("R4 ovf cleared by prod write", 32'(q_overflow), 0);
    wr(2'd2, 32'h0000_0007);
    chk("R6 full at split wrap", 32'(q_full), 1);

    // R10 register write wins over hardware
    hw(0, 1);
    step(1, 2'd3, 32'd1, 1, 1, 0, 7'd0);
    chk("R10 prod unchanged", prod_rdata, 32'h0000_000F);

    // R2 clamp to maximum
    wr(2'd0, 32'h2000_0014);
    chk("R2 raw readback", base_rdata, 32'h2000_0014);
    wr(2'd1, 0); wr(2'd2, 0);
    for (int i = 0; i < 257; i++) hw(1, 0);
    chk("R3 256 entries fit", 32'(q_full), 1);
    for (int i = 0; i < 257; i++) hw(0, 1);
    chk("R3 wrap bit set", cons_rdata, 32'h0000_0100);

    // single-entry queue
    wr(2'd0, 32'h3000_0000);
    wr(2'd1, 0); wr(2'd2, 0);
    hw(1, 0); hw(1, 0); hw(0, 1); hw(0, 1); hw(1, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    done = 1;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule